// File: doc/BRIEF.md
# Store-and-Replay Link Emulator with Fault Insertion

This block stands in for a storage device on a transceiver-style link. Each word on the link is 16 bits of data plus two flags, one for each byte, that mark the byte as a control character. On the receive side a small state machine waits for a start-of-packet symbol. It then writes every pure data word into an internal FIFO until an end-of-packet symbol closes the frame.

On the transmit side a second state machine sends comma idles until the host raises `send`. It then emits a start-of-packet symbol, drains the FIFO word by word and goes back to commas. A host-programmed mask is XORed into one chosen word of the replayed packet, so the error-correction path downstream sees a known fault. The control flags are never altered.

If a packet arrives with more data words than the FIFO can hold, a sticky flag is raised. The word that did not fit and the rest of that packet are discarded.

Top module: `ser_store_emu`

## Requirements
- R1: After reset `tx_data` is the comma 16'hBCBC with `tx_isk` = 2'b11, `ovf` is 0, and the mask and offset are 0.
- R2: While no replay is running and `send` is low, every output word is the comma (16'hBCBC, flags 2'b11).
- R3: A word is stored only when it lies between a start-of-packet (data 16'hFBFB, flags 2'b11) and an end-of-packet (data 16'hFDFD, flags 2'b11) and has flags 2'b00. Commas, words with either flag bit set, and words outside a frame are not stored.
- R4: When `send` is high in the idle state and the FIFO is not empty, the next output is the start-of-packet word. The stored words follow in arrival order, one per cycle, and then commas resume.
- R5: The word at index `offset` of the replayed payload is XORed with `mask`. Index 0 is the first word after start-of-packet. A host write with `cfg_sel` = 0 loads the mask and a write with `cfg_sel` = 1 loads the offset.
- R6: With a zero mask every replayed word equals the stored word.
- R7: Replayed payload words always carry flags 2'b00, whatever the mask.
- R8: A data word that arrives while the FIFO is full sets `ovf`. That word is dropped, and so is every later word of the same packet, even if space frees up. `ovf` stays set until reset. A new start-of-packet re-enables storing.
- R9: `send` with an empty FIFO leaves the output on commas.
- R10: The FIFO holds exactly `DEPTH` words without raising `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 16 | Incoming link word |
| rx_isk | input | 2 | Incoming per-byte control flags |
| send | input | 1 | Replay request, level sensitive |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_sel | input | 1 | 0 selects mask, 1 selects word offset |
| cfg_wdata | input | 16 | Host configuration value |
| tx_data | output | 16 | Outgoing link word |
| tx_isk | output | 2 | Outgoing per-byte control flags |
| ovf | output | 1 | Sticky overflow indication |

## Verification
The hardest case to reach is the overflow packet that keeps delivering data words while a replay is already emptying the FIFO. Only in that case does freed space tempt the receiver to resume storing. The stimulus fills the FIFO to capacity, pushes one more word, and then raises `send` while more data words of the same open frame are still arriving. A later empty-FIFO replay shows those words were never stored.

// File: rtl/ser_store_emu.sv
module ser_store_emu #(
  parameter int          DEPTH = 16,
  parameter logic [15:0] COMMA = 16'hBCBC,
  parameter logic [15:0] SOP   = 16'hFBFB,
  parameter logic [15:0] EOP   = 16'hFDFD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] rx_data,
  input  logic [1:0]  rx_isk,
  input  logic        send,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] tx_data,
  output logic [1:0]  tx_isk,
  output logic        ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          in_pkt, drop, tx_busy;
  logic [15:0]   mask_r, off_r, idx;

  wire rx_ctl    = (rx_isk == 2'b11);
  wire rx_sop    = rx_ctl && (rx_data == SOP);
  wire rx_eop    = rx_ctl && (rx_data == EOP);
  wire full      = (cnt == CW'(DEPTH));
  wire store_try = in_pkt && !drop && (rx_isk == 2'b00);
  wire push      = store_try && !full;
  wire pop       = tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      drop   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (rx_sop) begin
        in_pkt <= 1'b1;
        drop   <= 1'b0;
      end else if (rx_eop) begin
        in_pkt <= 1'b0;
      end
      if (store_try && full) begin
        drop <= 1'b1;
        ovf  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '0;
      off_r  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) off_r  <= cfg_wdata;
      else         mask_r <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_data <= COMMA;
      tx_isk  <= 2'b11;
      idx     <= '0;
    end else if (!tx_busy) begin
      tx_isk <= 2'b11;
      if (send && cnt != '0) begin
        tx_data <= SOP;
        tx_busy <= 1'b1;
        idx     <= '0;
      end else begin
        tx_data <= COMMA;
      end
    end else begin
      tx_data <= mem[rp] ^ ((idx == off_r) ? mask_r : 16'h0000);
      tx_isk  <= 2'b00;
      idx     <= idx + 16'd1;
      if (cnt == CW'(1) && !push) tx_busy <= 1'b0;
    end
  end

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r7_flags_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_isk != 2'b11) |-> (tx_isk == 2'b00));
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r4_sop_then_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_isk == 2'b11 && tx_data == SOP) |=> (tx_isk == 2'b00));
  a_r9_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cnt == '0) |=> (tx_data == COMMA && tx_isk == 2'b11));
  a_r3_no_store_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt && !tx_busy) |=> $stable(cnt));
endmodule

// File: tb/ser_store_emu_test.sv
`timescale 1ns/1ps
module ser_store_emu_test;
  localparam int D = 4;
  localparam logic [15:0] COMMA = 16'hBCBC, SOP = 16'hFBFB, EOP = 16'hFDFD;
  localparam logic [17:0] VEC [10] = '{
    {2'b11, 16'hBCBC}, {2'b00, 16'h1111}, {2'b11, 16'hFBFB}, {2'b00, 16'hA001},
    {2'b11, 16'hBCBC}, {2'b00, 16'hA002}, {2'b01, 16'h5A5A}, {2'b00, 16'hA003},
    {2'b11, 16'hFDFD}, {2'b00, 16'h2222}};

  logic clk = 0, rst_n = 0, send = 0, cfg_we = 0, cfg_sel = 0;
  logic [15:0] rx_data = COMMA, cfg_wdata = 0;
  logic [1:0]  rx_isk = 2'b11;
  logic [15:0] tx_data;
  logic [1:0]  tx_isk;
  logic        ovf;
  logic [15:0] exp_w [8];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_store_emu #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_isk(rx_isk), .send(send),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_data(tx_data), .tx_isk(tx_isk), .ovf(ovf));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_tx(input logic [15:0] ed, input logic [1:0] ek, input string tag);
    checks++;
    if (tx_data !== ed || tx_isk !== ek) begin
      fails++;
      $display("FAIL %s: tx=%h/%b expected %h/%b", tag, tx_data, tx_isk, ed, ek);
    end
  endtask

  task automatic chk_ovf(input logic e, input string tag);
    checks++;
    if (ovf !== e) begin
      fails++;
      $display("FAIL %s: ovf=%b expected %b", tag, ovf, e);
    end
  endtask

  task automatic cfg(input logic sel, input logic [15:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    step();
    cfg_we = 0;
  endtask

  task automatic rx(input logic [1:0] k, input logic [15:0] d);
    rx_isk = k; rx_data = d;
    step();
    rx_isk = 2'b11; rx_data = COMMA;
  endtask

  task automatic replay(input int n, input string tag);
    send = 1;
    step();
    chk_tx(SOP, 2'b11, tag);
    send = 0;
    for (int i = 0; i < n; i++) begin
      step();
      chk_tx(exp_w[i], 2'b00, tag);
    end
    step();
    chk_tx(COMMA, 2'b11, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1;
    chk_tx(COMMA, 2'b11, "R1");
    chk_ovf(0, "R1");
    step();
    chk_tx(COMMA, 2'b11, "R2");

    send = 1;
    step(); chk_tx(COMMA, 2'b11, "R9");
    step(); chk_tx(COMMA, 2'b11, "R9");
    send = 0;

    cfg(0, 16'h0101);
    cfg(1, 16'h0001);
    for (int i = 0; i < 10; i++) begin
      rx_isk = VEC[i][17:16]; rx_data = VEC[i][15:0];
      step();
      chk_tx(COMMA, 2'b11, "R2");
    end
    rx_isk = 2'b11; rx_data = COMMA;
    exp_w[0] = 16'hA001;
    exp_w[1] = 16'hA002 ^ 16'h0101;
    exp_w[2] = 16'hA003;
    replay(3, "R3/R4/R5");
    send = 1;
    step(); chk_tx(COMMA, 2'b11, "R3 ignored words not stored");
    send = 0;

    cfg(0, 16'h0000);
    rx(2'b11, SOP); rx(2'b00, 16'h1234); rx(2'b00, 16'h5678); rx(2'b11, EOP);
    exp_w[0] = 16'h1234; exp_w[1] = 16'h5678;
    replay(2, "R6");

    cfg(0, 16'hFFFF);
    cfg(1, 16'h0003);
    rx(2'b11, SOP);
    for (int i = 0; i < D; i++) rx(2'b00, 16'hB000 + 16'(i));
    rx(2'b11, EOP);
    chk_ovf(0, "R10");
    for (int i = 0; i < D; i++) exp_w[i] = 16'hB000 + 16'(i);
    exp_w[3] = exp_w[3] ^ 16'hFFFF;
    replay(D, "R10/R5/R7");

    cfg(0, 16'h0000);
    rx(2'b11, SOP);
    for (int i = 0; i < D; i++) rx(2'b00, 16'hC000 + 16'(i));
    chk_ovf(0, "R10 full no ovf");
    rx(2'b00, 16'hC0FF);
    chk_ovf(1, "R8");
    send = 1; rx_isk = 2'b00; rx_data = 16'hC0F5;
    step();
    chk_tx(SOP, 2'b11, "R8");
    send = 0; rx_data = 16'hC0F6;
    step();
    chk_tx(16'hC000, 2'b00, "R8");
    rx_isk = 2'b11; rx_data = COMMA;
    for (int i = 1; i < D; i++) begin
      step();
      chk_tx(16'hC000 + 16'(i), 2'b00, "R8");
    end
    step();
    chk_tx(COMMA, 2'b11, "R8");
    rx(2'b11, EOP);
    send = 1;
    step(); chk_tx(COMMA, 2'b11, "R8 rest of packet dropped");
    step(); chk_tx(COMMA, 2'b11, "R8 rest of packet dropped");
    send = 0;
    chk_ovf(1, "R8 sticky");

    rx(2'b11, SOP); rx(2'b00, 16'hD00D); rx(2'b11, EOP);
    exp_w[0] = 16'hD00D;
    replay(1, "R8 new packet stores");
    chk_ovf(1, "R8 sticky");

    rst_n = 0;
    step();
    rst_n = 1;
    chk_ovf(0, "R1/R8 reset clears");
    chk_tx(COMMA, 2'b11, "R1");
    send = 1;
    step(); chk_tx(COMMA, 2'b11, "R1 fifo emptied");
    send = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule